// File: doc/BRIEF.md
# Virtually Hinted Four-Way Cache Lookup

This block is the tag and data side of a small set-associative cache whose way selection does not wait for address translation. Every line holds a valid flag, a narrow virtual hint (the low bits of the virtual tag), a full physical tag and one data word. A lookup starts with a set index and a hint. The hint alone selects which way of the set is read, so no comparison against the full tags of all ways is needed. One cycle later the translated physical tag arrives and is compared with the stored tag of the selected way. That comparison alone decides hit or miss.

Fills write one line at a time and keep each set free of duplicate hints. A line whose hint matches the incoming fill is the victim, and any other same-hint line in that set is invalidated. With no hint match, a free way is used. When every way is taken, a per-set rotating pointer picks the victim. A fill has priority over a lookup to the same set, and the lookup is held off through a ready output. A flush input drops every line in one cycle.

Top module: `vh_lookup_unit`

## Requirements
- R1: After reset every line is invalid, `lk_ready` is high, no response is driven, and a lookup to any set misses.
- R2: When an accepted lookup's hint equals the hint of a valid line in its set and `lk_ptag` in the next cycle equals that line's physical tag, `rsp_hit` is high in that next cycle and `rsp_data` carries the line's data word.
- R3: When the hint selects a valid line but `lk_ptag` differs from its physical tag, the response is `rsp_miss` with `rsp_data` equal to zero.
- R4: When no valid line in the set carries the lookup's hint, the response is a miss, even if `lk_ptag` equals the physical tag stored under another hint in that set.
- R5: A fill whose hint matches a valid line in its set replaces that line. Afterwards the old physical tag misses, the new one hits, and no set ever holds two valid lines with the same hint.
- R6: A fill whose hint matches no valid line goes to a free way when the set has one, and every line already valid in the set keeps hitting.
- R7: While `fill_valid` is high and `fill_index` equals `lk_index`, `lk_ready` is low and the lookup is not accepted, so no response follows it. A lookup to a different set stays ready.
- R8: A cycle with `flush` high invalidates every line, so every lookup afterwards misses until new fills arrive.
- R9: A response appears only in the cycle after an accepted lookup. `rsp_hit` and `rsp_miss` are never high together, and both are low when no lookup was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines this cycle |
| lk_valid | input | 1 | Lookup request in stage one |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_index | input | IDX_W (3) | Set index of the lookup |
| lk_hint | input | HINT_W (2) | Virtual hint of the lookup |
| lk_ptag | input | PTAG_W (12) | Translated physical tag, one cycle after acceptance |
| rsp_hit | output | 1 | Lookup hit, data valid |
| rsp_miss | output | 1 | Lookup missed |
| rsp_data | output | DATA_W (16) | Data of the hitting line, zero otherwise |
| fill_valid | input | 1 | Write one line |
| fill_index | input | IDX_W (3) | Set index of the fill |
| fill_hint | input | HINT_W (2) | Virtual hint of the fill |
| fill_ptag | input | PTAG_W (12) | Physical tag of the fill |
| fill_data | input | DATA_W (16) | Data word of the fill |

## Verification
The lookup path is tried with four patterns. A hint and tag that both match show the hint-selected way is read. A matching hint with a foreign tag shows the tag alone decides the hit. A hint missing from the set, presented with a tag stored under another hint, shows a tag match without a hint match is not enough. A lookup to an empty set shows the behaviour after reset. Refills with a repeated hint are then looked up with both the old and the new tag. This separates a correct replacement from one that leaves a stale alias behind or overwrites a neighbouring way.

// File: rtl/vh_pkg.sv
package vh_pkg;

   typedef enum logic [1:0] {
      VSRC_NONE   = 2'd0,
      VSRC_ALIAS  = 2'd1,
      VSRC_FREE   = 2'd2,
      VSRC_ROTATE = 2'd3
   } vsrc_e;

   // index of the lowest set bit of vec, zero when vec is empty
   function automatic int unsigned lowest_set(input logic [31:0] vec);
      int unsigned idx;
      logic        found;
      idx   = 0;
      found = 1'b0;
      for (int i = 0; i < 32; i++) begin
         if (vec[i] && !found) begin
            idx   = i;
            found = 1'b1;
         end
      end
      return idx;
   endfunction

endpackage

// File: rtl/vh_hint_match.sv
module vh_hint_match #(
   parameter int NUM_WAYS = 4,
   parameter int HINT_W   = 2,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0]             set_valid,
   input  logic [NUM_WAYS-1:0][HINT_W-1:0] set_hint,
   input  logic [HINT_W-1:0]               probe_hint,
   output logic [NUM_WAYS-1:0]             match,
   output logic                            any,
   output logic [WAY_W-1:0]                way
);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign match[w] = set_valid[w] && (set_hint[w] == probe_hint);
   end

   assign any = |match;
   assign way = WAY_W'(vh_pkg::lowest_set(32'(match)));

endmodule

// File: rtl/vh_victim_pick.sv
module vh_victim_pick #(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                alias_any,
   input  logic [WAY_W-1:0]    alias_way,
   input  logic [NUM_WAYS-1:0] set_valid,
   input  logic [WAY_W-1:0]    rot_ptr,
   output logic [WAY_W-1:0]    victim,
   output vh_pkg::vsrc_e       src
);

   logic [NUM_WAYS-1:0] free_vec;
   logic [WAY_W-1:0]    free_way;

   assign free_vec = ~set_valid;
   assign free_way = WAY_W'(vh_pkg::lowest_set(32'(free_vec)));

   always_comb begin
      if (alias_any) begin
         victim = alias_way;
         src    = vh_pkg::VSRC_ALIAS;
      end else if (|free_vec) begin
         victim = free_way;
         src    = vh_pkg::VSRC_FREE;
      end else begin
         victim = rot_ptr;
         src    = vh_pkg::VSRC_ROTATE;
      end
   end

endmodule

// File: rtl/vh_line_store.sv
module vh_line_store #(
   parameter int NUM_SETS = 8,
   parameter int NUM_WAYS = 4,
   parameter int HINT_W   = 2,
   parameter int PTAG_W   = 12,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           flush,
   input  logic                                           wr_en,
   input  logic [IDX_W-1:0]                               wr_set,
   input  logic [WAY_W-1:0]                               wr_way,
   input  logic [NUM_WAYS-1:0]                            kill_mask,
   input  logic [HINT_W-1:0]                              wr_hint,
   input  logic [PTAG_W-1:0]                              wr_ptag,
   input  logic [DATA_W-1:0]                              wr_data,
   output logic [NUM_SETS-1:0][NUM_WAYS-1:0]              valid_o,
   output logic [NUM_SETS-1:0][NUM_WAYS-1:0][HINT_W-1:0]  hint_o,
   input  logic [IDX_W-1:0]                               rd_set,
   input  logic [WAY_W-1:0]                               rd_way,
   output logic [PTAG_W-1:0]                              rd_ptag,
   output logic [DATA_W-1:0]                              rd_data
);

   logic [NUM_SETS-1:0][NUM_WAYS-1:0]             valid_q;
   logic [NUM_SETS-1:0][NUM_WAYS-1:0][HINT_W-1:0] hint_q;
   logic [PTAG_W-1:0] ptag_q [NUM_SETS][NUM_WAYS];
   logic [DATA_W-1:0] data_q [NUM_SETS][NUM_WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == wr_way)
               valid_q[wr_set][w] <= 1'b1;
            else if (kill_mask[w])
               valid_q[wr_set][w] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hint_q <= '0;
      else if (wr_en && !flush)
         hint_q[wr_set][wr_way] <= wr_hint;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         ptag_q[wr_set][wr_way] <= wr_ptag;
         data_q[wr_set][wr_way] <= wr_data;
      end
   end

   assign valid_o = valid_q;
   assign hint_o  = hint_q;
   assign rd_ptag = ptag_q[rd_set][rd_way];
   assign rd_data = data_q[rd_set][rd_way];

endmodule

// File: rtl/vh_lookup_unit.sv
module vh_lookup_unit #(
   parameter int NUM_SETS = 8,
   parameter int NUM_WAYS = 4,
   parameter int HINT_W   = 2,
   parameter int PTAG_W   = 12,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_valid,
   output logic              lk_ready,
   input  logic [IDX_W-1:0]  lk_index,
   input  logic [HINT_W-1:0] lk_hint,
   input  logic [PTAG_W-1:0] lk_ptag,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_index,
   input  logic [HINT_W-1:0] fill_hint,
   input  logic [PTAG_W-1:0] fill_ptag,
   input  logic [DATA_W-1:0] fill_data
);

   initial begin
      if (NUM_WAYS < 2 || (1 << WAY_W) != NUM_WAYS)
         $error("vh_lookup_unit: NUM_WAYS must be a power of two of at least 2");
      if (NUM_SETS < 2 || (1 << IDX_W) != NUM_SETS)
         $error("vh_lookup_unit: NUM_SETS must be a power of two of at least 2");
      if (NUM_WAYS > 32)
         $error("vh_lookup_unit: NUM_WAYS above 32 is not supported");
      if (HINT_W < 1 || PTAG_W < 1 || DATA_W < 1)
         $error("vh_lookup_unit: field widths must be positive");
   end

   logic [NUM_SETS-1:0][NUM_WAYS-1:0]             line_valid;
   logic [NUM_SETS-1:0][NUM_WAYS-1:0][HINT_W-1:0] line_hint;

   // ---------------- stage one: hint-only way choice ----------------
   logic                lk_go;
   logic [NUM_WAYS-1:0] lk_match;
   logic                lk_any;
   logic [WAY_W-1:0]    lk_way;

   assign lk_ready = !flush && !(fill_valid && (fill_index == lk_index));
   assign lk_go    = lk_valid && lk_ready;

   vh_hint_match #(.NUM_WAYS(NUM_WAYS), .HINT_W(HINT_W)) u_lk_match (
      .set_valid  (line_valid[lk_index]),
      .set_hint   (line_hint[lk_index]),
      .probe_hint (lk_hint),
      .match      (lk_match),
      .any        (lk_any),
      .way        (lk_way)
   );

   logic             s1_valid;
   logic             s1_sel;
   logic [IDX_W-1:0] s1_index;
   logic [WAY_W-1:0] s1_way;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sel   <= 1'b0;
         s1_index <= '0;
         s1_way   <= '0;
      end else begin
         s1_valid <= lk_go;
         if (lk_go) begin
            s1_sel   <= lk_any;
            s1_index <= lk_index;
            s1_way   <= lk_way;
         end
      end
   end

   // ---------------- fill path: victim and alias removal ----------------
   logic                fill_go;
   logic [NUM_WAYS-1:0] fl_match;
   logic                fl_any;
   logic [WAY_W-1:0]    fl_way;
   logic [WAY_W-1:0]    victim;
   vh_pkg::vsrc_e       vsrc;
   logic [NUM_WAYS-1:0] kill_mask;
   logic [NUM_SETS-1:0][WAY_W-1:0] rot_q;

   assign fill_go = fill_valid && !flush;

   vh_hint_match #(.NUM_WAYS(NUM_WAYS), .HINT_W(HINT_W)) u_fl_match (
      .set_valid  (line_valid[fill_index]),
      .set_hint   (line_hint[fill_index]),
      .probe_hint (fill_hint),
      .match      (fl_match),
      .any        (fl_any),
      .way        (fl_way)
   );

   vh_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_victim (
      .alias_any (fl_any),
      .alias_way (fl_way),
      .set_valid (line_valid[fill_index]),
      .rot_ptr   (rot_q[fill_index]),
      .victim    (victim),
      .src       (vsrc)
   );

   always_comb begin
      for (int w = 0; w < NUM_WAYS; w++)
         kill_mask[w] = fl_match[w] && (WAY_W'(w) != victim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rot_q <= '0;
      else if (fill_go && vsrc == vh_pkg::VSRC_ROTATE)
         rot_q[fill_index] <= rot_q[fill_index] + 1'b1;
   end

   // ---------------- line storage ----------------
   logic [PTAG_W-1:0] rd_ptag;
   logic [DATA_W-1:0] rd_data;

   vh_line_store #(
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS),
      .HINT_W   (HINT_W),
      .PTAG_W   (PTAG_W),
      .DATA_W   (DATA_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (fill_go),
      .wr_set    (fill_index),
      .wr_way    (victim),
      .kill_mask (kill_mask),
      .wr_hint   (fill_hint),
      .wr_ptag   (fill_ptag),
      .wr_data   (fill_data),
      .valid_o   (line_valid),
      .hint_o    (line_hint),
      .rd_set    (s1_index),
      .rd_way    (s1_way),
      .rd_ptag   (rd_ptag),
      .rd_data   (rd_data)
   );

   // ---------------- stage two: physical tag decides ----------------
   logic tag_eq;
   assign tag_eq   = line_valid[s1_index][s1_way] && (rd_ptag == lk_ptag);
   assign rsp_hit  = s1_valid && s1_sel && tag_eq;
   assign rsp_miss = s1_valid && !rsp_hit;
   assign rsp_data = rsp_hit ? rd_data : '0;

endmodule

// File: rtl/vh_lookup_unit_chk.sv
module vh_lookup_unit_chk #(
   parameter int NUM_SETS = 8,
   parameter int NUM_WAYS = 4,
   parameter int HINT_W   = 2,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = $clog2(NUM_SETS)
) (
   input logic                                          clk,
   input logic                                          rst_n,
   input logic                                          flush,
   input logic                                          lk_valid,
   input logic                                          lk_ready,
   input logic [IDX_W-1:0]                              lk_index,
   input logic                                          fill_valid,
   input logic [IDX_W-1:0]                              fill_index,
   input logic                                          rsp_hit,
   input logic                                          rsp_miss,
   input logic [DATA_W-1:0]                             rsp_data,
   input logic [NUM_SETS-1:0][NUM_WAYS-1:0]             line_valid,
   input logic [NUM_SETS-1:0][NUM_WAYS-1:0][HINT_W-1:0] line_hint
);

   logic hint_dup;
   always_comb begin
      hint_dup = 1'b0;
      for (int s = 0; s < NUM_SETS; s++)
         for (int i = 0; i < NUM_WAYS; i++)
            for (int j = i + 1; j < NUM_WAYS; j++)
               if (line_valid[s][i] && line_valid[s][j] &&
                   line_hint[s][i] == line_hint[s][j])
                  hint_dup = 1'b1;
   end

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_miss));                                              // R9
   AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> (rsp_hit || rsp_miss));                    // R9
   AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_miss) |-> $past(lk_valid && lk_ready));               // R9
   AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_data == '0));                                       // R3
   AST_FILL_HOLDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && lk_valid && fill_index == lk_index) |-> !lk_ready);   // R7
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (line_valid == '0));                                        // R8
   AST_HINT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      !hint_dup);                                                           // R5

endmodule

bind vh_lookup_unit vh_lookup_unit_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS),
   .HINT_W   (HINT_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .lk_valid   (lk_valid),
   .lk_ready   (lk_ready),
   .lk_index   (lk_index),
   .fill_valid (fill_valid),
   .fill_index (fill_index),
   .rsp_hit    (rsp_hit),
   .rsp_miss   (rsp_miss),
   .rsp_data   (rsp_data),
   .line_valid (line_valid),
   .line_hint  (line_hint)
);

// File: tb/vh_lookup_unit_tb.sv
module vh_lookup_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic        lk_ready;
   logic [2:0]  lk_index = '0;
   logic [1:0]  lk_hint = '0;
   logic [11:0] lk_ptag = '0;
   logic        rsp_hit;
   logic        rsp_miss;
   logic [15:0] rsp_data;
   logic        fill_valid = 1'b0;
   logic [2:0]  fill_index = '0;
   logic [1:0]  fill_hint = '0;
   logic [11:0] fill_ptag = '0;
   logic [15:0] fill_data = '0;

   int n_checks = 0;
   int n_fail   = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   vh_lookup_unit u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
      .lk_hint(lk_hint), .lk_ptag(lk_ptag),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_data(rsp_data),
      .fill_valid(fill_valid), .fill_index(fill_index), .fill_hint(fill_hint),
      .fill_ptag(fill_ptag), .fill_data(fill_data)
   );

   // op 1 = fill, 0 = lookup; exp = {hit, miss, data}
   typedef struct packed {
      logic        op;
      logic [2:0]  idx;
      logic [1:0]  hint;
      logic [11:0] ptag;
      logic [15:0] data;
      logic        exp_hit;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [0:15] = '{
      '{1'b1, 3'd3, 2'd0, 12'h111, 16'hA0A0, 1'b0, 4'd6},
      '{1'b1, 3'd3, 2'd1, 12'h222, 16'hB1B1, 1'b0, 4'd6},
      '{1'b1, 3'd3, 2'd2, 12'h333, 16'hC2C2, 1'b0, 4'd6},
      '{1'b1, 3'd3, 2'd3, 12'h444, 16'hD3D3, 1'b0, 4'd6},
      '{1'b0, 3'd3, 2'd0, 12'h111, 16'hA0A0, 1'b1, 4'd2},  // R2
      '{1'b0, 3'd3, 2'd2, 12'h333, 16'hC2C2, 1'b1, 4'd2},  // R2, R6
      '{1'b0, 3'd3, 2'd1, 12'h999, 16'h0000, 1'b0, 4'd3},  // R3
      '{1'b0, 3'd5, 2'd0, 12'h111, 16'h0000, 1'b0, 4'd4},  // R4 empty set
      '{1'b1, 3'd3, 2'd1, 12'h555, 16'hE4E4, 1'b0, 4'd5},
      '{1'b0, 3'd3, 2'd1, 12'h222, 16'h0000, 1'b0, 4'd5},  // R5 old tag gone
      '{1'b0, 3'd3, 2'd1, 12'h555, 16'hE4E4, 1'b1, 4'd5},  // R5 new tag
      '{1'b0, 3'd3, 2'd3, 12'h444, 16'hD3D3, 1'b1, 4'd5},  // R5 neighbour kept
      '{1'b0, 3'd3, 2'd0, 12'h111, 16'hA0A0, 1'b1, 4'd6},  // R6
      '{1'b1, 3'd5, 2'd2, 12'h333, 16'h1234, 1'b0, 4'd6},
      '{1'b0, 3'd5, 2'd2, 12'h333, 16'h1234, 1'b1, 4'd2},  // R2
      '{1'b0, 3'd5, 2'd1, 12'h333, 16'h0000, 1'b0, 4'd4}   // R4 tag under other hint
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_fill(input logic [2:0] idx, input logic [1:0] hint,
                          input logic [11:0] ptag, input logic [15:0] data);
      @(negedge clk);
      fill_valid = 1'b1; fill_index = idx; fill_hint = hint;
      fill_ptag = ptag; fill_data = data;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_lookup(input logic [2:0] idx, input logic [1:0] hint,
                            input logic [11:0] ptag, output logic [17:0] rsp);
      @(negedge clk);
      lk_valid = 1'b1; lk_index = idx; lk_hint = hint;
      @(negedge clk);
      lk_valid = 1'b0; lk_ptag = ptag;
      #1;
      rsp = {rsp_hit, rsp_miss, rsp_data};
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      logic [17:0] r;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      check("R1", "ready after reset", {31'd0, lk_ready}, 32'd1);
      check("R1", "no response after reset", {30'd0, rsp_hit, rsp_miss}, 32'd0);
      do_lookup(3'd0, 2'd0, 12'h000, r);
      check("R1", "lookup after reset", {14'd0, r}, {14'd0, 2'b01, 16'h0000});

      // table walk
      for (int i = 0; i < 16; i++) begin
         if (VEC[i].op) begin
            do_fill(VEC[i].idx, VEC[i].hint, VEC[i].ptag, VEC[i].data);
         end else begin
            do_lookup(VEC[i].idx, VEC[i].hint, VEC[i].ptag, r);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i),
                  {14'd0, r},
                  {14'd0, VEC[i].exp_hit, !VEC[i].exp_hit, VEC[i].data});
         end
      end

      // R9: idle cycle gives no response
      @(negedge clk); #1;
      check("R9", "idle no response", {30'd0, rsp_hit, rsp_miss}, 32'd0);

      // R7: fill holds off a same-set lookup
      @(negedge clk);
      fill_valid = 1'b1; fill_index = 3'd5; fill_hint = 2'd3;
      fill_ptag = 12'h777; fill_data = 16'h7777;
      lk_valid = 1'b1; lk_index = 3'd4; lk_hint = 2'd0;
      #1;
      check("R7", "other set stays ready", {31'd0, lk_ready}, 32'd1);
      lk_index = 3'd5; lk_hint = 2'd3;
      #1;
      check("R7", "same set held off", {31'd0, lk_ready}, 32'd0);
      @(negedge clk);
      fill_valid = 1'b0; lk_valid = 1'b0; lk_ptag = 12'h777;
      #1;
      check("R7", "held lookup gives no response", {30'd0, rsp_hit, rsp_miss}, 32'd0);
      do_lookup(3'd5, 2'd3, 12'h777, r);
      check("R7", "fill took effect", {14'd0, r}, {14'd0, 2'b10, 16'h7777});

      // R8: flush drops all lines
      @(negedge clk);
      flush = 1'b1;
      #1;
      check("R8", "not ready during flush", {31'd0, lk_ready}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      do_lookup(3'd3, 2'd0, 12'h111, r);
      check("R8", "set 3 after flush", {14'd0, r}, {14'd0, 2'b01, 16'h0000});
      do_lookup(3'd5, 2'd2, 12'h333, r);
      check("R8", "set 5 after flush", {14'd0, r}, {14'd0, 2'b01, 16'h0000});

      // R5/R6 after flush: refill works again
      do_fill(3'd3, 2'd2, 12'hABC, 16'h5A5A);
      do_lookup(3'd3, 2'd2, 12'hABC, r);
      check("R6", "refill after flush", {14'd0, r}, {14'd0, 2'b10, 16'h5A5A});

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1_600_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule